// File: doc/BRIEF.md
# SDRAM Bring-Up Command Sequencer

This block issues the fixed start-up command stream that an SDRAM needs before it can take ordinary traffic. After a synchronous reset it holds the command pins at NOP for the power-up settling time. It then closes every bank with a precharge-all and runs a set number of auto-refresh cycles. Last, it writes the configured mode word into the mode register. Each command lasts one clock, and every gap between commands is a clock count worked out from a nanosecond figure and the clock period.

A memory controller places this block in front of its command and address pins. It hands the pins over once `ready` rises. The mode word is a parameter. Its reserved bits and the top address bit are always driven low, whatever value that parameter carries.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the pins show NOP (CS#=0, RAS#=1, CAS#=1, WE#=1), the address is zero and `ready` is low.
- R2: The precharge-all appears right after the WAIT_CYC-th rising edge at which `rst` is low. WAIT_CYC = ceil(WAIT_NS*1000/CLK_PS), with a floor of 2.
- R3: Precharge-all is encoded as CS#,RAS#,CAS#,WE# = 0,0,1,0. Address bit 10 is high and every other address bit is zero.
- R4: Exactly REF_COUNT auto-refresh commands are issued, encoded 0,0,0,1 with a zero address. The first one comes TRP_CYC cycles after the precharge-all, where TRP_CYC = ceil(TRP_NS*1000/CLK_PS) with a floor of 2.
- R5: Each refresh is followed TRFC_CYC cycles later by the next command (another refresh or the mode load). TRFC_CYC = ceil(TRFC_NS*1000/CLK_PS) with a floor of 2.
- R6: The mode load is encoded 0,0,0,0. Address bits 9:0 carry MODE_VAL[9:0]: burst length in 2:0, burst type in 3, CAS latency in 6:4, operating mode in 8:7 and write-burst mode in 9. Address bits 12:10 are zero whatever MODE_VAL holds.
- R7: Each command occupies a single cycle. Every cycle that carries none of the commands in R3 to R6 shows NOP with a zero address.
- R8: `ready` rises TMRD_CYC cycles after the mode-load cycle and stays high until the next reset. While `ready` is high the pins show NOP.
- R9: A reset at any point, including during a gap or after `ready`, restarts the whole sequence from the power-up wait. `ready` is low after the first edge that samples the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus driven with each command |
| ready | output | 1 | High once the bring-up is complete |

## Verification
The bench builds the block with a 4000 ps clock and a power-up wait of 200 ns, which gives 50 cycles. This shortened wait is what lets it walk the whole sequence several times, including restarts from mid-gap and from the finished state. The other timings stay at their defaults: 15 ns becomes 4 cycles, 66 ns becomes 17 cycles and the mode-load wait is 2 cycles. The 15 ns figure rounds up, so the ceiling conversion gets exercised. MODE_VAL is set to 13'h1C32, so reserved and top bits are set on purpose and the forced zeros on address bits 12:10 can be seen at the pins.

// File: rtl/sdr_bringup_pkg.sv
package sdr_bringup_pkg;

    typedef enum logic [2:0] {
        PH_WAIT     = 3'd0,
        PH_PRE      = 3'd1,
        PH_PRE_GAP  = 3'd2,
        PH_REF      = 3'd3,
        PH_REF_GAP  = 3'd4,
        PH_MRS      = 3'd5,
        PH_MRS_GAP  = 3'd6,
        PH_DONE     = 3'd7
    } bringup_phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Address bit that selects all banks on a precharge
    localparam int ALL_BANKS_BIT = 10;
    // Number of mode-word bits that carry defined fields
    localparam int MODE_FIELD_W  = 10;

    // Nanoseconds to whole clock cycles, rounded up, never below 2
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        longint num;
        longint cyc;
        num = longint'(ns) * 64'sd1000;
        cyc = (num + longint'(clk_ps) - 64'sd1) / longint'(clk_ps);
        if (cyc < 64'sd2) cyc = 64'sd2;
        return int'(cyc);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdr_bringup_timer.sv
module sdr_bringup_timer #(
    parameter int TW      = 8,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

    AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired); // R7

endmodule

// File: rtl/sdr_bringup_ctrl.sv
module sdr_bringup_ctrl
    import sdr_bringup_pkg::*;
#(
    parameter int TW        = 8,
    parameter int TRP_CYC   = 2,
    parameter int TRFC_CYC  = 2,
    parameter int TMRD_CYC  = 2,
    parameter int REF_COUNT = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tmr_expired,
    output logic           tmr_load,
    output logic [TW-1:0]  tmr_val,
    output bringup_phase_e phase
);

    localparam int RCW = $clog2(REF_COUNT + 1);
    localparam logic [TW-1:0]  TRP_LOAD  = TW'(TRP_CYC - 2);
    localparam logic [TW-1:0]  TRFC_LOAD = TW'(TRFC_CYC - 2);
    localparam logic [TW-1:0]  TMRD_LOAD = TW'(TMRD_CYC - 2);
    localparam logic [RCW-1:0] REF_LAST  = RCW'(REF_COUNT);

    bringup_phase_e phase_q, phase_d;
    logic [RCW-1:0] refs_q, refs_d;

    always_comb begin
        phase_d  = phase_q;
        refs_d   = refs_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_WAIT: begin
                if (tmr_expired) phase_d = PH_PRE;
            end
            PH_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = TRP_LOAD;
                phase_d  = PH_PRE_GAP;
            end
            PH_PRE_GAP: begin
                if (tmr_expired) phase_d = PH_REF;
            end
            PH_REF: begin
                tmr_load = 1'b1;
                tmr_val  = TRFC_LOAD;
                refs_d   = refs_q + 1'b1;
                phase_d  = PH_REF_GAP;
            end
            PH_REF_GAP: begin
                if (tmr_expired) begin
                    phase_d = (refs_q == REF_LAST) ? PH_MRS : PH_REF;
                end
            end
            PH_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = TMRD_LOAD;
                phase_d  = PH_MRS_GAP;
            end
            PH_MRS_GAP: begin
                if (tmr_expired) phase_d = PH_DONE;
            end
            default: phase_d = PH_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WAIT;
            refs_q  <= '0;
        end else begin
            phase_q <= phase_d;
            refs_q  <= refs_d;
        end
    end

    assign phase = phase_q;

    AST_REFS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_REF) |-> (refs_q < REF_LAST)); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |=> (phase_q == PH_DONE)); // R8

endmodule

// File: rtl/sdr_bringup_cmd_enc.sv
module sdr_bringup_cmd_enc
    import sdr_bringup_pkg::*;
#(
    parameter int              ADDR_W   = 13,
    parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
    input  bringup_phase_e    phase,
    output sdr_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        case (phase)
            PH_PRE: begin
                cmd                 = CMD_PRE;
                addr[ALL_BANKS_BIT] = 1'b1;
            end
            PH_REF: begin
                cmd = CMD_REF;
            end
            PH_MRS: begin
                cmd                     = CMD_LMR;
                addr[MODE_FIELD_W-1:0]  = MODE_VAL[MODE_FIELD_W-1:0];
            end
            default: begin
                cmd  = CMD_NOP;
                addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
    import sdr_bringup_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                CLK_PS    = 4000,
    parameter int                WAIT_NS   = 100000,
    parameter int                TRP_NS    = 15,
    parameter int                TRFC_NS   = 66,
    parameter int                TMRD_CYC  = 2,
    parameter int                REF_COUNT = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL  = 13'h0032
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);

    localparam int WAIT_CYC = ns_to_cycles(WAIT_NS, CLK_PS);
    localparam int TRP_CYC  = ns_to_cycles(TRP_NS, CLK_PS);
    localparam int TRFC_CYC = ns_to_cycles(TRFC_NS, CLK_PS);
    localparam int MAX_CYC  = max3(WAIT_CYC, TRP_CYC, (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC);
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam int RCW      = $clog2(REF_COUNT + 1);

    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_expired;
    bringup_phase_e phase;
    sdr_cmd_t       cmd;

    sdr_bringup_timer #(
        .TW      (TW),
        .RST_VAL (WAIT_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdr_bringup_ctrl #(
        .TW        (TW),
        .TRP_CYC   (TRP_CYC),
        .TRFC_CYC  (TRFC_CYC),
        .TMRD_CYC  (TMRD_CYC),
        .REF_COUNT (REF_COUNT)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .phase       (phase)
    );

    sdr_bringup_cmd_enc #(
        .ADDR_W   (ADDR_W),
        .MODE_VAL (MODE_VAL)
    ) u_enc (
        .phase (phase),
        .cmd   (cmd),
        .addr  (addr)
    );

    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign ready     = (phase == PH_DONE);

    // Pin-level tracking for the assertions below
    logic [RCW-1:0] pin_refs_q;
    logic           pin_lmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_refs_q <= '0;
            pin_lmr_q  <= 1'b0;
        end else begin
            if (cmd == CMD_REF) pin_refs_q <= pin_refs_q + 1'b1;
            if (cmd == CMD_LMR) pin_lmr_q  <= 1'b1;
        end
    end

    AST_LMR_AFTER_REFS: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LMR) |-> (pin_refs_q == RCW'(REF_COUNT))); // R4

    AST_LMR_RSVD_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LMR) |-> (addr[ADDR_W-1:MODE_FIELD_W] == '0)); // R6

    AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP)); // R7

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R8

    AST_READY_NEEDS_LMR: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pin_lmr_q && cmd == CMD_NOP)); // R8

endmodule

// File: tb/sdr_bringup_seq_bench.sv
module sdr_bringup_seq_bench;

    localparam int CLK_PS   = 4000;
    localparam int WAIT_NS  = 200;
    localparam int TRP_NS   = 15;
    localparam int TRFC_NS  = 66;
    localparam int TMRD_CYC = 2;
    localparam logic [12:0] MODE_RAW = 13'h1C32;

    // Expected cycle counts worked out from the requirements
    localparam int W_CYC    = 50;   // 200 ns / 4 ns
    localparam int P_CYC    = 4;    // 15 ns / 4 ns rounded up
    localparam int F_CYC    = 17;   // 66 ns / 4 ns rounded up
    localparam int S_PRE    = W_CYC - 1;
    localparam int S_REF1   = S_PRE + P_CYC;
    localparam int S_REF2   = S_REF1 + F_CYC;
    localparam int S_LMR    = S_REF2 + F_CYC;
    localparam int S_RDY    = S_LMR + TMRD_CYC;

    typedef struct packed {
        int          s;
        logic [3:0]  cmd;
        logic [12:0] addr;
    } ev_t;

    localparam ev_t EVS [5] = '{
        '{s: S_PRE,  cmd: 4'b0010, addr: 13'h0400},  // R2 R3
        '{s: S_REF1, cmd: 4'b0001, addr: 13'h0000},  // R4
        '{s: S_REF2, cmd: 4'b0001, addr: 13'h0000},  // R5
        '{s: S_LMR,  cmd: 4'b0000, addr: 13'h0032},  // R5 R6
        '{s: S_RDY,  cmd: 4'b0111, addr: 13'h0000}   // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n, ras_n, cas_n, we_n, ready;
    logic [12:0] addr;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #2ns clk = ~clk;

    sdr_bringup_seq #(
        .ADDR_W    (13),
        .CLK_PS    (CLK_PS),
        .WAIT_NS   (WAIT_NS),
        .TRP_NS    (TRP_NS),
        .TRFC_NS   (TRFC_NS),
        .TMRD_CYC  (TMRD_CYC),
        .REF_COUNT (2),
        .MODE_VAL  (MODE_RAW)
    ) u_sdr_bringup_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_cs_n  (cs_n),
        .cmd_ras_n (ras_n),
        .cmd_cas_n (cas_n),
        .cmd_we_n  (we_n),
        .addr      (addr),
        .ready     (ready)
    );

    function automatic logic [17:0] pins();
        return {cs_n, ras_n, cas_n, we_n, addr, ready};
    endfunction

    task automatic chk(input string tag, input logic [17:0] exp);
        logic [17:0] act;
        act = pins();
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h (cmd,addr,ready)", tag, act, exp);
        end
    endtask

    function automatic string ev_tag(input int i);
        case (i)
            0: return "R2/R3 precharge";
            1: return "R4 first refresh";
            2: return "R5 second refresh";
            3: return "R6 mode load";
            default: return "R8 ready";
        endcase
    endfunction

    localparam logic [17:0] NOP_LO = {4'b0111, 13'h0000, 1'b0};
    localparam logic [17:0] NOP_HI = {4'b0111, 13'h0000, 1'b1};

    // Walk from release of reset up to and including cycle last_s
    task automatic walk_to(input int last_s, input string tag);
        for (int s = 0; s <= last_s; s++) begin
            @(negedge clk);
            if (s == S_PRE) chk(tag, {EVS[0].cmd, EVS[0].addr, 1'b0});
            else            chk(tag, NOP_LO);
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1/R9 reset held", NOP_LO);
        end
        rst = 1'b0;
    endtask

    initial begin
        // R1: state during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 reset state", NOP_LO);
        end
        rst = 1'b0;

        // Table walk over the whole sequence: R2..R8, NOPs between (R7)
        begin
            int cur;
            cur = -1;
            for (int e = 0; e < 5; e++) begin
                while (cur < EVS[e].s) begin
                    @(negedge clk);
                    cur++;
                    if (cur == EVS[e].s)
                        chk(ev_tag(e), {EVS[e].cmd, EVS[e].addr, (e == 4) ? 1'b1 : 1'b0});
                    else
                        chk("R7 nop between commands", NOP_LO);
                end
            end
        end

        // R8: ready held with NOP on the pins
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk("R8 ready held", NOP_HI);
        end

        // R9: reset after ready, sequence restarts from the wait
        do_reset(2);
        walk_to(S_PRE, "R9 restart after ready");

        // R9: reset in the middle of the precharge gap
        @(negedge clk);
        chk("R7 gap after precharge", NOP_LO);
        do_reset(1);
        walk_to(S_PRE + 2, "R9 restart from gap");

        // R9: reset during the power-up wait itself
        do_reset(3);
        walk_to(20, "R9 restart from wait");
        do_reset(1);
        walk_to(S_REF1 - 1, "R2 wait recount");
        @(negedge clk);
        chk("R4 refresh after restart", {4'b0001, 13'h0000, 1'b0});

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule